// File: doc/BRIEF.md
# Wrapping Burst Column Address Generator

This block turns one column command into the series of column addresses for a single read or write burst in a DDR2-style memory controller. It takes a start column, a burst length of four or eight from the mode settings, and a start strobe. For each beat it presents one column address with a valid flag, and it marks the final beat. Reads and writes use the same sequence.

The burst never leaves an aligned group of columns that is as wide as the burst length. The upper column bits pick the group and do not change during the burst. The low bits begin at the start position, count up by one on each beat, and wrap back to the base of the same group. They never carry into the upper bits. The burst length is captured when the strobe is accepted and applies to the whole burst. A strobe that arrives while a burst is running has no effect on the sequence and is reported on a busy flag.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and after it is released until the first start is accepted, `valid_o`, `last_o` and `busy_o` are low.
- R2: A `start_i` sampled high at a rising edge while no burst is active starts a burst. From the next cycle `valid_o` is high and `col_o` equals the sampled `start_col_i`.
- R3: With `bl8_i` = 0 (length 4), the burst lasts 4 beats. Bits 1:0 of `col_o` increase by one per beat modulo 4, and bits COL_W-1:2 keep the start value.
- R4: With `bl8_i` = 1 (length 8), the burst lasts 8 beats. Bits 2:0 of `col_o` increase by one per beat modulo 8, and bits COL_W-1:3 keep the start value.
- R5: `last_o` is high only on the final beat, which is beat 3 for length 4 and beat 7 for length 8, counting from 0. In the cycle after it, `valid_o` is low unless a new burst starts.
- R6: A `start_i` sampled while a burst is active, including on its final beat, is ignored and the running sequence continues unchanged. `busy_o` is high for exactly the following cycle.
- R7: `bl8_i` is sampled only when a start is accepted. Changing it during a burst does not change that burst's length or wrap point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one burst |
| start_col_i | input | COL_W | Start column address |
| bl8_i | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented on `col_o` |
| last_o | output | 1 | Current beat is the final one of the burst |
| busy_o | output | 1 | A strobe was ignored in the previous cycle |

## Verification
The stimulus runs bursts of both lengths from start offsets at the base of a group, inside it, and at its top. These cases separate correct wrapping from a plain increment and from a carry into the group-select bits. Some starts use all-ones columns, which expose a carry out of the address field. Strobes injected in the middle of a burst and on its final beat, with the opposite length selected, show whether a strobe can restart the counter, change the length, or be missed by the busy flag.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int BEAT_W = 3;

  // Final beat index for the selected burst length.
  function automatic logic [BEAT_W-1:0] final_beat(input logic len8);
    return len8 ? 3'd7 : 3'd3;
  endfunction

  // Next low column field: 3-bit wrap for length 8, 2-bit wrap for length 4
  // (bit 2 is then part of the group select and is held).
  function automatic logic [2:0] next_low(input logic [2:0] lo, input logic len8);
    logic [2:0] nx;
    if (len8) nx = lo + 3'd1;
    else      nx = {lo[2], lo[1:0] + 2'd1};
    return nx;
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bl8_i,
  output logic              valid_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              accept_o,
  output logic              step_o,
  output logic              len8_o,
  output logic [BEAT_W-1:0] beat_o
);

  logic              valid_q;
  logic              len8_q;
  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic              reject_w;
  logic              final_w;

  assign accept_o = start_i & ~valid_q;
  assign reject_w = start_i & valid_q;
  assign final_w  = valid_q && (beat_q == final_beat(len8_q));
  assign step_o   = valid_q & ~final_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      len8_q  <= 1'b0;
      busy_q  <= 1'b0;
      beat_q  <= '0;
    end else begin
      busy_q <= reject_w;
      if (accept_o) begin
        valid_q <= 1'b1;
        len8_q  <= bl8_i;
        beat_q  <= '0;
      end else if (final_w) begin
        valid_q <= 1'b0;
      end else if (valid_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign last_o  = final_w;
  assign busy_o  = busy_q;
  assign len8_o  = len8_q;
  assign beat_o  = beat_q;

endmodule

// File: rtl/burst_col_step.sv
module burst_col_step
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             len8_i,
  input  logic [COL_W-1:0] start_col_i,
  output logic [COL_W-1:0] col_o
);

  localparam int LOW_W = 3;
  localparam int GRP_W = COL_W - LOW_W;

  logic [COL_W-1:0] col_q;
  logic [LOW_W-1:0] low_nx_w;

  assign low_nx_w = next_low(col_q[LOW_W-1:0], len8_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (load_i) begin
      col_q <= start_col_i;
    end else if (step_i) begin
      col_q <= {col_q[COL_W-1:LOW_W], low_nx_w};
    end
  end

  assign col_o = col_q;

  initial begin
    if (GRP_W < 1) $error("COL_W must be at least 4");
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             bl8_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o
);

  logic              accept_w;
  logic              step_w;
  logic              len8_w;
  logic [BEAT_W-1:0] beat_w;

  burst_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bl8_i    (bl8_i),
    .valid_o  (valid_o),
    .last_o   (last_o),
    .busy_o   (busy_o),
    .accept_o (accept_w),
    .step_o   (step_w),
    .len8_o   (len8_w),
    .beat_o   (beat_w)
  );

  burst_col_step #(.COL_W(COL_W)) u_step (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept_w),
    .step_i      (step_w),
    .len8_i      (len8_w),
    .start_col_i (start_col_i),
    .col_o       (col_o)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             bl8_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             busy_o,
  input logic             len8_w,
  input logic [2:0]       beat_w
);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o) |=> (valid_o && col_o == $past(start_col_i))); // R2

  AST_BL4_GROUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !len8_w) |=> (col_o[COL_W-1:2] == $past(col_o[COL_W-1:2]))); // R3

  AST_BL4_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !len8_w) |=> (col_o[1:0] == $past(col_o[1:0]) + 2'd1)); // R3

  AST_BL8_GROUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && len8_w) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]))); // R4

  AST_BL8_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && len8_w) |=> (col_o[2:0] == $past(col_o[2:0]) + 3'd1)); // R4

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (valid_o && beat_w == (len8_w ? 3'd7 : 3'd3))); // R5

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o); // R5

  AST_BUSY_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && valid_o) |=> busy_o); // R6

  AST_BUSY_ONLY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(start_i && valid_o)) |=> !busy_o); // R6

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> $stable(len8_w)); // R7

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl8_i       (bl8_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .busy_o      (busy_o),
  .len8_w      (len8_w),
  .beat_w      (beat_w)
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

  localparam int COL_W = 10;
  localparam int NVEC  = 8;

  // Each entry: {length-8 select, start column}
  localparam logic [COL_W:0] VEC [NVEC] = '{
    {1'b0, 10'h000}, {1'b0, 10'h003}, {1'b0, 10'h3FE}, {1'b1, 10'h155},
    {1'b1, 10'h007}, {1'b1, 10'h3FF}, {1'b0, 10'h2A6}, {1'b1, 10'h0C9}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic             bl8_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl8_i(bl8_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
    .busy_o(busy_o)
  );

  function automatic int exp_col(input int start, input bit len8, input int k);
    int len = len8 ? 8 : 4;
    int base = start - (start % len);
    return base + ((start % len + k) % len);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one burst; disturb >= 0 injects an opposite strobe after beat 'disturb'.
  task automatic run_burst(input int c, input bit len8, input int disturb);
    int len = len8 ? 8 : 4;
    @(negedge clk);
    start_i = 1'b1; start_col_i = COL_W'(c); bl8_i = len8;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      check(valid_o === 1'b1, "R2 valid", int'(valid_o), 1);
      check(int'(col_o) == exp_col(c, len8, k), len8 ? "R4 col" : "R3 col",
            int'(col_o), exp_col(c, len8, k));
      check(last_o === (k == len - 1), "R5 last", int'(last_o), int'(k == len - 1));
      if (disturb >= 0 && k == disturb + 1)
        check(busy_o === 1'b1, "R6 busy", int'(busy_o), 1);
      else
        check(busy_o === 1'b0, "R6 no busy", int'(busy_o), 0);
      if (k == disturb) begin
        start_i = 1'b1; start_col_i = ~COL_W'(c); bl8_i = ~len8;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o === 1'b0, "R5 end valid", int'(valid_o), 0);
    check(last_o === 1'b0, "R5 end last", int'(last_o), 0);
    check(busy_o === (disturb == len - 1), "R6 busy end", int'(busy_o),
          int'(disturb == len - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0 && busy_o === 1'b0, "R1 in reset",
          {valid_o, last_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0 && busy_o === 1'b0, "R1 after reset",
          {valid_o, last_o, busy_o}, 0);

    for (int v = 0; v < NVEC; v++)
      run_burst(int'(VEC[v][COL_W-1:0]), VEC[v][COL_W], -1);

    // R6 R7: strobe mid-burst with opposite length, length 4 burst
    run_burst(10'h0F2, 1'b0, 1);
    // R6 R7: strobe mid-burst, length 8 burst
    run_burst(10'h23D, 1'b1, 4);
    // R6: strobe on final beat is ignored
    run_burst(10'h105, 1'b0, 3);
    run_burst(10'h3FA, 1'b1, 7);

    // R7: length select toggled alone during a burst
    @(negedge clk);
    start_i = 1'b1; start_col_i = 10'h1F6; bl8_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      bl8_i = k[0];
      check(int'(col_o) == exp_col(10'h1F6, 1'b1, k), "R7 col",
            int'(col_o), exp_col(10'h1F6, 1'b1, k));
      check(last_o === (k == 7), "R7 last", int'(last_o), int'(k == 7));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule